// File: doc/BRIEF.md
# Contiguous Free-Run Finder

The block keeps one valid bit for each entry of a table and answers the question "where is the lowest place, inside a given window, that holds a run of consecutive free entries of a given length?" A request supplies a window base index, a window length and the run length needed. The block scans candidate start positions one per clock, beginning at the window base. It ends with a one-cycle done pulse, a found flag and the winning start index.

When the request asks for it, the block marks the winning run as valid on the same clock edge that reports success. A second request therefore always sees those entries as taken. A separate release command clears any run of entries back to free. The table's valid bits are visible at the boundary so that the surrounding logic can observe occupancy.

Top module: `run_finder`

## Requirements
- R1: After reset every valid bit is 0, and busy_o, done_o and found_o are low.
- R2: A request whose run length is 0, or larger than its window length, completes on the accepting clock edge itself: done_o is high right after that edge, found_o is low and no valid bit changes.
- R3: For a well-formed request, the returned start is the lowest index s with base <= s <= base + window - need such that entries s to s + need - 1 are all free.
- R4: Entries outside the window never decide the result, and a run that would extend past the last table entry is never returned.
- R5: When no start qualifies, done_o pulses with found_o low and no valid bit changes.
- R6: When a request has commit set and succeeds, the valid bits of the winning run become 1 on the edge that raises done_o; with commit clear, the table is left unchanged.
- R7: A release command sets to 0 every entry from its start index for its length, limited to the table, and leaves every other entry unchanged; a length of 0 changes nothing.
- R8: busy_o is high from acceptance of a well-formed request until the edge that raises done_o, and requests presented while busy_o is high are ignored.
- R9: With acceptance at edge A, done_o rises after edge A + k + 1 on success, where k is the returned start minus the base, and after edge A + (window - need + 1) on failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Search request, taken when busy_o is low |
| req_base_i | input | IDX_W | First index of the search window |
| req_span_i | input | CNT_W | Number of entries in the window |
| req_need_i | input | CNT_W | Length of the free run wanted |
| req_commit_i | input | 1 | Mark the winning run valid on success |
| rel_valid_i | input | 1 | Release command |
| rel_start_i | input | IDX_W | First entry to release |
| rel_len_i | input | CNT_W | Number of entries to release |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Last search succeeded |
| start_o | output | IDX_W | Start index of the last successful run |
| valid_o | output | N_ENTRIES | Current valid bits of the table |

## Verification
The search is tried on an empty table, on tables with a blocker at the front or blocks with gaps both shorter and longer than the run, on windows placed away from index 0, and on windows that reach the table end. These patterns separate a correct first-fit search from one that skips the first candidate, stops one candidate early or late, ignores the window base, or allows a run to wrap past the last entry. The reported latency of each case pins down the one-candidate-per-clock order. Requests with commit clear, malformed requests, requests issued while busy, and releases that are partial, clipped or empty show that only the intended entries ever change.

// File: rtl/run_finder_pkg.sv
package run_finder_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_SCAN} scan_state_e;
endpackage

// File: rtl/run_span_mask.sv
module run_span_mask #(
  parameter int unsigned N  = 32,
  parameter int unsigned SW = 6,
  parameter int unsigned LW = 6
) (
  input  logic [SW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  output logic [N-1:0]  mask_o,
  output logic          ovf_o
);
  localparam int unsigned EW = ((SW > LW) ? SW : LW) + 1;

  logic [EW-1:0] end_w;
  assign end_w = EW'(start_i) + EW'(len_i);
  assign ovf_o = end_w > EW'(N);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign mask_o[i] = (EW'(start_i) <= EW'(i)) && (EW'(i) < end_w);
  end
endmodule

// File: rtl/run_alloc_table.sv
module run_alloc_table #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic [N-1:0] set_mask_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] valid_o
);
  logic [N-1:0] valid_q;
  logic [N-1:0] clr_w, set_w;

  assign clr_w = clr_en_i ? clr_mask_i : '0;
  assign set_w = set_en_i ? set_mask_i : '0;

  // set wins over clear on overlap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= (valid_q & ~clr_w) | set_w;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/run_search_ctrl.sv
module run_search_ctrl
  import run_finder_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned EXT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_base_i,
  input  logic [CNT_W-1:0] req_span_i,
  input  logic [CNT_W-1:0] req_need_i,
  input  logic             req_commit_i,
  input  logic             hit_i,
  output logic [EXT_W-1:0] cand_o,
  output logic [CNT_W-1:0] need_o,
  output logic             set_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             found_o,
  output logic [IDX_W-1:0] start_o
);
  scan_state_e      state_q;
  logic [EXT_W-1:0] cand_q, last_q, last_d;
  logic [CNT_W-1:0] need_q;
  logic             commit_q, done_q, found_q;
  logic [IDX_W-1:0] start_q;
  logic             accept, bad_req, scanning;

  assign scanning = (state_q == ST_SCAN);
  assign accept   = req_valid_i && !scanning;
  assign bad_req  = (req_need_i == '0) || (req_need_i > req_span_i);
  assign last_d   = EXT_W'(req_base_i) + EXT_W'(req_span_i) - EXT_W'(req_need_i);
  assign set_en_o = scanning && hit_i && commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cand_q   <= '0;
      last_q   <= '0;
      need_q   <= '0;
      commit_q <= 1'b0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
      start_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (bad_req) begin
          done_q  <= 1'b1;
          found_q <= 1'b0;
        end else begin
          state_q  <= ST_SCAN;
          cand_q   <= EXT_W'(req_base_i);
          last_q   <= last_d;
          need_q   <= req_need_i;
          commit_q <= req_commit_i;
        end
      end else if (scanning) begin
        if (hit_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          found_q <= 1'b1;
          start_q <= cand_q[IDX_W-1:0];
        end else if (cand_q == last_q) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          found_q <= 1'b0;
        end else begin
          cand_q <= cand_q + 1'b1;
        end
      end
    end
  end

  assign cand_o  = cand_q;
  assign need_o  = need_q;
  assign busy_o  = scanning;
  assign done_o  = done_q;
  assign found_o = found_q;
  assign start_o = start_q;
endmodule

// File: rtl/run_finder.sv
module run_finder #(
  parameter int unsigned N_ENTRIES = 32,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int unsigned CNT_W = $clog2(N_ENTRIES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [IDX_W-1:0]     req_base_i,
  input  logic [CNT_W-1:0]     req_span_i,
  input  logic [CNT_W-1:0]     req_need_i,
  input  logic                 req_commit_i,
  input  logic                 rel_valid_i,
  input  logic [IDX_W-1:0]     rel_start_i,
  input  logic [CNT_W-1:0]     rel_len_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 found_o,
  output logic [IDX_W-1:0]     start_o,
  output logic [N_ENTRIES-1:0] valid_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [EXT_W-1:0]     cand;
  logic [CNT_W-1:0]     need;
  logic [N_ENTRIES-1:0] cand_mask, rel_mask, valid;
  logic                 cand_ovf, rel_ovf_unused, hit, set_en;

  run_span_mask #(.N(N_ENTRIES), .SW(EXT_W), .LW(CNT_W)) i_cand_mask (
    .start_i(cand), .len_i(need), .mask_o(cand_mask), .ovf_o(cand_ovf)
  );

  run_span_mask #(.N(N_ENTRIES), .SW(IDX_W), .LW(CNT_W)) i_rel_mask (
    .start_i(rel_start_i), .len_i(rel_len_i), .mask_o(rel_mask), .ovf_o(rel_ovf_unused)
  );

  // a candidate wins only if the whole run lies inside the table and is free
  assign hit = !cand_ovf && ((valid & cand_mask) == '0);

  run_search_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W), .EXT_W(EXT_W)) i_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_base_i, .req_span_i, .req_need_i, .req_commit_i,
    .hit_i(hit), .cand_o(cand), .need_o(need), .set_en_o(set_en),
    .busy_o, .done_o, .found_o, .start_o
  );

  run_alloc_table #(.N(N_ENTRIES)) i_table (
    .clk_i, .rst_ni,
    .set_en_i(set_en), .set_mask_i(cand_mask),
    .clr_en_i(rel_valid_i), .clr_mask_i(rel_mask),
    .valid_o(valid)
  );

  assign valid_o = valid;
endmodule

// File: rtl/run_finder_chk.sv
module run_finder_chk #(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned CNT_W = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [IDX_W-1:0]     req_base_i,
  input logic [CNT_W-1:0]     req_span_i,
  input logic [CNT_W-1:0]     req_need_i,
  input logic                 req_commit_i,
  input logic                 rel_valid_i,
  input logic [IDX_W-1:0]     rel_start_i,
  input logic [CNT_W-1:0]     rel_len_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 found_o,
  input logic [IDX_W-1:0]     start_o,
  input logic [N_ENTRIES-1:0] valid_o
);
  localparam int unsigned EW = CNT_W + 2;

  logic [IDX_W-1:0] base_q;
  logic [CNT_W-1:0] span_q, need_q;
  logic             commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; span_q <= '0; need_q <= '0; commit_q <= 1'b0;
    end else if (req_valid_i && !busy_o) begin
      base_q <= req_base_i; span_q <= req_span_i;
      need_q <= req_need_i; commit_q <= req_commit_i;
    end
  end

  a_r2_bad_req_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && ((req_need_i == '0) || (req_need_i > req_span_i))
      |=> done_o && !found_o);

  a_r3_start_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && found_o |-> (start_o >= base_q) &&
      (EW'(start_o) + EW'(need_q) <= EW'(base_q) + EW'(span_q)));

  a_r5_miss_keeps_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !found_o && !$past(rel_valid_i) |-> $stable(valid_o));

  a_r6_commit_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && found_o && commit_q |-> valid_o[start_o]);

  a_r7_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i && (rel_len_i != '0) |=> done_o || !valid_o[$past(rel_start_i)]);

  a_r8_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o);
endmodule

bind run_finder run_finder_chk #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_run_finder_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_base_i(req_base_i), .req_span_i(req_span_i),
  .req_need_i(req_need_i), .req_commit_i(req_commit_i),
  .rel_valid_i(rel_valid_i), .rel_start_i(rel_start_i), .rel_len_i(rel_len_i),
  .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .start_o(start_o),
  .valid_o(valid_o)
);

// File: tb/test_run_finder.sv
module test_run_finder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_base = '0;
  logic [5:0]  req_span = '0;
  logic [5:0]  req_need = '0;
  logic        req_commit = 1'b0;
  logic        rel_valid = 1'b0;
  logic [4:0]  rel_start = '0;
  logic [5:0]  rel_len = '0;
  logic        busy, done, found;
  logic [4:0]  start;
  logic [31:0] valid;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  run_finder i_run_finder (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_base_i(req_base), .req_span_i(req_span),
    .req_need_i(req_need), .req_commit_i(req_commit),
    .rel_valid_i(rel_valid), .rel_start_i(rel_start), .rel_len_i(rel_len),
    .busy_o(busy), .done_o(done), .found_o(found), .start_o(start), .valid_o(valid)
  );

  typedef struct packed {
    logic [31:0] pat;
    logic [4:0]  base;
    logic [5:0]  span;
    logic [5:0]  need;
    logic        commit;
    logic        found;
    logic [4:0]  start;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 5'd0,  6'd32, 6'd4, 1'b1, 1'b1, 5'd0,  8'd1},  // empty table
    '{32'h0000_000F, 5'd0,  6'd32, 6'd4, 1'b1, 1'b1, 5'd4,  8'd5},  // front blocked
    '{32'h0000_0F0F, 5'd0,  6'd32, 6'd4, 1'b1, 1'b1, 5'd4,  8'd5},  // gap fits exactly
    '{32'h0000_0F0F, 5'd0,  6'd32, 6'd5, 1'b1, 1'b1, 5'd12, 8'd13}, // gap too short
    '{32'h0000_0000, 5'd10, 6'd4,  6'd4, 1'b1, 1'b1, 5'd10, 8'd1},  // R4 offset window
    '{32'h0000_0400, 5'd8,  6'd6,  6'd3, 1'b1, 1'b1, 5'd11, 8'd4},  // R4 blocker in window
    '{32'h0000_0400, 5'd8,  6'd5,  6'd3, 1'b1, 1'b0, 5'd0,  8'd3},  // R4 window one short
    '{32'h0000_0000, 5'd0,  6'd3,  6'd4, 1'b1, 1'b0, 5'd0,  8'd0},  // need > window
    '{32'h0000_0000, 5'd0,  6'd32, 6'd0, 1'b1, 1'b0, 5'd0,  8'd0},  // need zero
    '{32'h0000_0000, 5'd30, 6'd4,  6'd3, 1'b1, 1'b0, 5'd0,  8'd2},  // R4 past table end
    '{32'hFFFF_FFFE, 5'd0,  6'd32, 6'd1, 1'b0, 1'b1, 5'd0,  8'd1},  // no commit
    '{32'h7FFF_FFFF, 5'd0,  6'd32, 6'd1, 1'b1, 1'b1, 5'd31, 8'd32}  // last entry
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [4:0] b, input logic [5:0] sp, input logic [5:0] nd,
                        input logic cm, output logic f, output logic [4:0] s, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_base = b; req_span = sp; req_need = nd; req_commit = cm;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    if (!done) chk(1'b0, "R9 timeout", 64'(lat), 64'd0);
    f = found; s = start;
  endtask

  task automatic do_rel(input logic [4:0] s, input logic [5:0] l);
    @(negedge clk);
    rel_valid = 1'b1; rel_start = s; rel_len = l;
    @(posedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic preset(input logic [31:0] p);
    logic f;
    logic [4:0] s;
    int lat;
    do_rel(5'd0, 6'd32);
    for (int i = 0; i < 32; i++)
      if (p[i]) do_req(5'(i), 6'd1, 6'd1, 1'b1, f, s, lat);
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    chk(1'b0, "watchdog", 64'(cyc), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic f;
    logic [4:0] s;
    int lat;
    logic [31:0] exp_tab;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid == 32'h0, "R1 valid", 64'(valid), 64'd0);
    chk(!busy && !done && !found, "R1 flags", {busy, done, found}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = (v == 4 || v == 5 || v == 6 || v == 9) ? "R4" : "R3";
      preset(VECS[v].pat);
      chk(valid == VECS[v].pat, "R6 preset", 64'(valid), 64'(VECS[v].pat));
      do_req(VECS[v].base, VECS[v].span, VECS[v].need, VECS[v].commit, f, s, lat);
      chk(f == VECS[v].found, (VECS[v].lat == 0) ? "R2 found" : "R5 found", 64'(f), 64'(VECS[v].found));
      if (VECS[v].found) chk(s == VECS[v].start, tg, 64'(s), 64'(VECS[v].start));
      chk(lat == int'(VECS[v].lat), "R9 latency", 64'(lat), 64'(VECS[v].lat));
      exp_tab = VECS[v].pat;
      if (VECS[v].found && VECS[v].commit)
        for (int i = 0; i < 32; i++)
          if (i >= int'(VECS[v].start) && i < int'(VECS[v].start) + int'(VECS[v].need)) exp_tab[i] = 1'b1;
      chk(valid == exp_tab, VECS[v].found ? "R6 table" : "R5 table", 64'(valid), 64'(exp_tab));
    end

    // R8: second request during a long search is ignored
    preset(32'h7FFF_FFFF);
    @(negedge clk);
    req_valid = 1'b1; req_base = 5'd0; req_span = 6'd32; req_need = 6'd1; req_commit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(busy, "R8 busy", 64'(busy), 64'd1);
    req_need = 6'd0;  // would complete at once if taken
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (lat == 3) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk(lat == 32, "R8 latency", 64'(lat), 64'd32);
    chk(found && start == 5'd31, "R8 result", {found, start}, {1'b1, 5'd31});
    chk(valid == 32'hFFFF_FFFF, "R8 table", 64'(valid), 64'hFFFF_FFFF);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R8 no extra done", 64'(done), 64'd0);

    // R7 release
    do_rel(5'd5, 6'd3);
    chk(valid == 32'hFFFF_FF1F, "R7 partial", 64'(valid), 64'hFFFF_FF1F);
    do_rel(5'd30, 6'd5);
    chk(valid == 32'h3FFF_FF1F, "R7 clipped", 64'(valid), 64'h3FFF_FF1F);
    do_rel(5'd12, 6'd0);
    chk(valid == 32'h3FFF_FF1F, "R7 empty", 64'(valid), 64'h3FFF_FF1F);

    // R3 released gap becomes the first fit
    do_req(5'd0, 6'd32, 6'd2, 1'b1, f, s, lat);
    chk(f && s == 5'd5, "R3 after release", {f, s}, {1'b1, 5'd5});
    chk(valid == 32'h3FFF_FF7F, "R6 commit after release", 64'(valid), 64'h3FFF_FF7F);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule